// File: doc/BRIEF.md
# Addressed Serial Receiver with Multiprocessor-Bit Filtering

This block receives asynchronous serial frames that carry one extra address-marker bit after the data byte. It takes a 16x oversampling baud tick from outside and the raw serial line. It confirms each start bit at mid-bit and samples every later bit at its centre. The received byte goes into a data register, and a full flag tells software that a byte is waiting.

Several receivers can share one line. Software arms a filter that drops every frame whose marker bit is 0. When a frame with the marker set arrives, it is stored as an address byte and the filter disarms itself. Software compares that byte with its own address. On a mismatch it re-arms the filter. On a match it leaves the filter off, and the data frames that follow are stored.

Overrun and framing errors are sticky, and software clears them. While either one is set, the receiver starts no new frame. A break output reports a line that has stayed low for a whole frame time after a framing error.

Top module: `mpr_uart_rx`

## Requirements
- R1: A frame is a 0 start bit, then DATA_W data bits with the LSB first, then one marker bit, then a stop bit of 1. The data bits appear on rx_data with bit 0 as the first data bit received.
- R2: When a frame is accepted, rx_data is loaded and rx_full goes to 1. A clr_full pulse returns rx_full to 0. rx_data changes only when a frame is accepted.
- R3: A set_filter pulse sets filter_en to 1. While filter_en is 1, a frame whose marker bit is 0 changes no output.
- R4: A frame whose marker bit is 1 is stored even while filter_en is 1, and it clears filter_en to 0 in the same cycle that rx_full rises.
- R5: If a valid frame completes while rx_full is 1, ovr_err goes to 1, rx_data keeps its old value and filter_en is left unchanged.
- R6: If the stop bit is sampled as 0, frm_err goes to 1, and rx_data, rx_full and filter_en are left unchanged. clr_ovr and clr_frm each clear their own flag.
- R7: While ovr_err or frm_err is 1, line activity starts no frame. Once both flags are 0, reception resumes.
- R8: A low level on the line is taken as a start bit only if the line is still low OVS/2 ticks after the low level is first seen. A shorter low pulse changes no output.
- R9: break_det is 1 only while frm_err is 1 and the synchronized line has been low for OVS*(DATA_W+3) consecutive baud ticks. It returns to 0 when the line goes high.
- R10: rx_irq equals rx_full OR ovr_err OR frm_err.
- R11: After reset, rx_data is 0 and rx_full, ovr_err, frm_err, filter_en, break_det and rx_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| set_filter | input | 1 | Pulse that arms the marker filter |
| clr_full | input | 1 | Pulse that clears rx_full |
| clr_ovr | input | 1 | Pulse that clears ovr_err |
| clr_frm | input | 1 | Pulse that clears frm_err |
| rx_data | output | DATA_W | Last accepted byte |
| rx_full | output | 1 | Byte waiting for software |
| ovr_err | output | 1 | Overrun flag, sticky |
| frm_err | output | 1 | Framing error flag, sticky |
| filter_en | output | 1 | Marker filter armed |
| break_det | output | 1 | Break condition seen on the line |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A bit counter or tick counter that is off by one shifts the sampling point. The effect shows up as a wrong rx_data value or a spurious frm_err in the same cycle the frame completes. The bench compares every port on every clock against a behavioural model, so a slip of even one cycle in flag timing is caught at once. A wrong filter or blocking state does not show up right away. It appears one frame later, as a byte that should have been dropped, or as a frame that is stored while an error flag is still set.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_BITS,
      ST_STOP
   } rx_state_e;

   function automatic int frame_ticks(input int ovs, input int dw);
      return ovs * (dw + 3);
   endfunction
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RST_VAL}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
   import mpr_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            rs,
   input  logic            hold,
   output logic            done,
   output logic            stop_ok,
   output logic [DATA_W:0] payload
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] MARK_IDX  = BIT_W'(DATA_W);

   rx_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [BIT_W-1:0] bidx;
   logic [DATA_W:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         shreg <= '0;
      end else if (tick) begin
         unique case (st)
            ST_IDLE: begin
               if (!rs && !hold) begin
                  st  <= ST_START;
                  cnt <= '0;
               end
            end
            ST_START: begin
               if (cnt == HALF_LAST) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= rs ? ST_IDLE : ST_BITS;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BITS: begin
               if (cnt == FULL_LAST) begin
                  cnt   <= '0;
                  shreg <= {rs, shreg[DATA_W:1]};
                  if (bidx == MARK_IDX) st <= ST_STOP;
                  else                  bidx <= bidx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == FULL_LAST) begin
                  cnt <= '0;
                  st  <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done    = tick && (st == ST_STOP) && (cnt == FULL_LAST);
   assign stop_ok = rs;
   assign payload = shreg;
endmodule

// File: rtl/mpr_flags.sv
module mpr_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              stop_ok,
   input  logic [DATA_W:0]   payload,
   input  logic              set_filter,
   input  logic              clr_full,
   input  logic              clr_ovr,
   input  logic              clr_frm,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              ovr_q,
   output logic              frm_q,
   output logic              filt_q
);
   logic marker;
   logic drop;
   logic store;
   logic overrun;
   logic bad_stop;

   assign marker   = payload[DATA_W];
   assign bad_stop = done && !stop_ok;
   assign drop     = done && stop_ok && filt_q && !marker;
   assign overrun  = done && stop_ok && !drop && full_q;
   assign store    = done && stop_ok && !drop && !full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         frm_q  <= 1'b0;
         filt_q <= 1'b0;
      end else begin
         if (store) begin
            data_q <= payload[DATA_W-1:0];
            full_q <= 1'b1;
         end else if (clr_full) begin
            full_q <= 1'b0;
         end

         if (overrun)      ovr_q <= 1'b1;
         else if (clr_ovr) ovr_q <= 1'b0;

         if (bad_stop)     frm_q <= 1'b1;
         else if (clr_frm) frm_q <= 1'b0;

         if (set_filter)            filt_q <= 1'b1;
         else if (store && marker)  filt_q <= 1'b0;
      end
   end
endmodule

// File: rtl/mpr_break.sv
module mpr_break #(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rs,
   input  logic frm,
   output logic brk
);
   localparam int LIMIT = mpr_pkg::frame_ticks(OVS, DATA_W);
   localparam int BW    = $clog2(LIMIT + 1);
   localparam logic [BW-1:0] LIM = BW'(LIMIT);

   logic [BW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!frm || rs) begin
         low_cnt <= '0;
      end else if (tick && low_cnt != LIM) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign brk = frm && (low_cnt == LIM);
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx #(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BREAK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              baud_tick,
   input  logic              set_filter,
   input  logic              clr_full,
   input  logic              clr_ovr,
   input  logic              clr_frm,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              ovr_err,
   output logic              frm_err,
   output logic              filter_en,
   output logic              break_det,
   output logic              rx_irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_dw
         $error("DATA_W must be between 5 and 9");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic            rs;
   logic            done;
   logic            stop_ok;
   logic [DATA_W:0] payload;
   logic            hold;

   assign hold = ovr_err | frm_err;

   mpr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rs)
   );

   mpr_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .rs      (rs),
      .hold    (hold),
      .done    (done),
      .stop_ok (stop_ok),
      .payload (payload)
   );

   mpr_flags #(.DATA_W(DATA_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .stop_ok    (stop_ok),
      .payload    (payload),
      .set_filter (set_filter),
      .clr_full   (clr_full),
      .clr_ovr    (clr_ovr),
      .clr_frm    (clr_frm),
      .data_q     (rx_data),
      .full_q     (rx_full),
      .ovr_q      (ovr_err),
      .frm_q      (frm_err),
      .filt_q     (filter_en)
   );

   generate
      if (BREAK_EN) begin : g_brk
         mpr_break #(.OVS(OVS), .DATA_W(DATA_W)) u_brk (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (baud_tick),
            .rs    (rs),
            .frm   (frm_err),
            .brk   (break_det)
         );
      end else begin : g_nobrk
         assign break_det = 1'b0;
      end
   endgenerate

   assign rx_irq = rx_full | ovr_err | frm_err;
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              set_filter,
   input logic              clr_full,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              ovr_err,
   input logic              frm_err,
   input logic              filter_en,
   input logic              break_det
);
   // R2: the data register moves only together with a rising full flag
   a_r2_data_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> $rose(rx_full));

   // R4: filter disarms only by a stored marker frame
   a_r4_filter_drop_on_store: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filter_en) |-> $rose(rx_full));

   // R5: overrun keeps the old byte
   a_r5_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> $stable(rx_data));

   // R6: a framing error stores nothing
   a_r6_frm_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err) |-> ($stable(rx_data) && !$rose(rx_full)));

   // R7: no frame is stored while an error flag was set
   a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ovr_err || frm_err) |-> !$rose(rx_full));

   // R9: break only alongside a framing error
   a_r9_break_needs_frm: assert property (@(posedge clk) disable iff (!rst_n)
      break_det |-> frm_err);

   // R3: arming pulse always leaves the filter on
   a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
      set_filter |=> filter_en);
endmodule

bind mpr_uart_rx mpr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_filter (set_filter),
   .clr_full   (clr_full),
   .rx_data    (rx_data),
   .rx_full    (rx_full),
   .ovr_err    (ovr_err),
   .frm_err    (frm_err),
   .filter_en  (filter_en),
   .break_det  (break_det)
);

// File: tb/mpr_uart_rx_test.sv
`timescale 1ns/1ps
module mpr_uart_rx_test;
   localparam int OVS   = 16;
   localparam int DW    = 8;
   localparam int TDIV  = 4;
   localparam int BITC  = OVS * TDIV;
   localparam int FRAME = OVS * (DW + 3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_in = 1'b1;
   logic baud_tick = 1'b0;
   logic set_filter = 1'b0, clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0;
   logic [DW-1:0] rx_data;
   logic rx_full, ovr_err, frm_err, filter_en, break_det, rx_irq;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done_run = 1'b0;

   always #2.5 clk = ~clk;

   mpr_uart_rx #(.OVS(OVS), .DATA_W(DW), .SYNC_STAGES(2), .BREAK_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
      .set_filter(set_filter), .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm),
      .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err), .frm_err(frm_err),
      .filter_en(filter_en), .break_det(break_det), .rx_irq(rx_irq)
   );

   // tick generator
   always @(negedge clk) begin
      cyc <= cyc + 1;
      baud_tick <= ((cyc % TDIV) == 0);
   end

   // behavioural reference model
   bit d1, d2, rsm;
   int m_st, m_cnt, m_bit, m_bcnt;
   logic [DW:0] m_bits;
   logic [DW-1:0] m_data;
   bit m_full, m_ovr, m_frm, m_filt, m_done, m_stop, full_old;

   always @(posedge clk) begin
      if (!rst_n) begin
         d1 = 1; d2 = 1; m_st = 0; m_cnt = 0; m_bit = 0; m_bcnt = 0; m_bits = '0;
         m_data = '0; m_full = 0; m_ovr = 0; m_frm = 0; m_filt = 0;
      end else begin
         rsm = d2; d2 = d1; d1 = rx_in;
         m_done = 0;
         if (baud_tick) begin
            case (m_st)
               0: if (!rsm && !(m_ovr || m_frm)) begin m_st = 1; m_cnt = 0; end
               1: if (m_cnt == OVS/2 - 1) begin
                     m_cnt = 0; m_bit = 0; m_st = rsm ? 0 : 2;
                  end else m_cnt++;
               2: if (m_cnt == OVS - 1) begin
                     m_cnt = 0; m_bits[m_bit] = rsm;
                     if (m_bit == DW) m_st = 3; else m_bit++;
                  end else m_cnt++;
               default: if (m_cnt == OVS - 1) begin
                     m_cnt = 0; m_st = 0; m_done = 1; m_stop = rsm;
                  end else m_cnt++;
            endcase
         end
         if (!m_frm || rsm) m_bcnt = 0;
         else if (baud_tick && m_bcnt < FRAME) m_bcnt++;
         full_old = m_full;
         if (clr_full) m_full = 0;
         if (clr_ovr)  m_ovr = 0;
         if (clr_frm)  m_frm = 0;
         if (m_done) begin
            if (!m_stop) m_frm = 1;
            else if (m_filt && !m_bits[DW]) begin end
            else if (full_old) m_ovr = 1;
            else begin
               m_data = m_bits[DW-1:0]; m_full = 1;
               if (m_bits[DW]) m_filt = 0;
            end
         end
         if (set_filter) m_filt = 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         check(rx_data == m_data, "R1/R2 rx_data", rx_data, m_data);
         check(rx_full == m_full, "R2 rx_full", rx_full, m_full);
         check(filter_en == m_filt, "R3/R4 filter_en", filter_en, m_filt);
         check(ovr_err == m_ovr, "R5 ovr_err", ovr_err, m_ovr);
         check(frm_err == m_frm, "R6 frm_err", frm_err, m_frm);
         check(break_det == (m_frm && m_bcnt == FRAME), "R9 break_det", break_det,
               (m_frm && m_bcnt == FRAME));
         check(rx_irq == (m_full | m_ovr | m_frm), "R10 rx_irq", rx_irq, (m_full | m_ovr | m_frm));
      end
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: set_filter = 1'b1;
         1: clr_full = 1'b1;
         2: clr_ovr = 1'b1;
         default: clr_frm = 1'b1;
      endcase
      @(negedge clk);
      set_filter = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0;
   endtask

   task automatic send_frame(input logic [DW-1:0] b, input bit mp, input bit stopv);
      @(negedge clk); rx_in = 1'b0; wait_clks(BITC);
      for (int i = 0; i < DW; i++) begin rx_in = b[i]; wait_clks(BITC); end
      rx_in = mp; wait_clks(BITC);
      rx_in = stopv; wait_clks(BITC);
      rx_in = 1'b1; wait_clks(2 * BITC);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done_run) begin
         done_run = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_clks(6);
      // R11 reset state
      check(rx_data == 0 && !rx_full && !ovr_err && !frm_err && !filter_en && !break_det && !rx_irq,
            "R11 reset outputs", {rx_data, rx_full, ovr_err, frm_err, filter_en, break_det, rx_irq}, 0);
      rst_n = 1'b1;
      wait_clks(10);

      // R3 arm filter, data frame dropped
      pulse(0);
      check(filter_en == 1, "R3 filter armed", filter_en, 1);
      send_frame(8'hC3, 1'b0, 1'b1);
      check(!rx_full && rx_data == 0 && filter_en, "R3 dropped frame", {rx_full, rx_data}, 0);

      // R4 address frame stored, filter disarms; R1 LSB first
      send_frame(8'h5A, 1'b1, 1'b1);
      check(rx_full && rx_data == 8'h5A, "R1 R4 address byte", rx_data, 8'h5A);
      check(!filter_en, "R4 filter cleared", filter_en, 0);
      check(rx_irq, "R10 irq on full", rx_irq, 1);

      // R2 clear, data frame accepted with filter off
      pulse(1);
      check(!rx_full, "R2 full cleared", rx_full, 0);
      send_frame(8'h3C, 1'b0, 1'b1);
      check(rx_full && rx_data == 8'h3C, "R2 data byte", rx_data, 8'h3C);

      // R5 overrun
      send_frame(8'h81, 1'b0, 1'b1);
      check(ovr_err && rx_data == 8'h3C, "R5 overrun keeps data", {ovr_err, rx_data}, {1'b1, 8'h3C});

      // R7 blocked while error set
      pulse(1);
      send_frame(8'h77, 1'b0, 1'b1);
      check(!rx_full && rx_data == 8'h3C, "R7 blocked frame", {rx_full, rx_data}, {1'b0, 8'h3C});
      pulse(2);
      send_frame(8'h77, 1'b0, 1'b1);
      check(rx_full && rx_data == 8'h77, "R7 resumed", rx_data, 8'h77);
      pulse(1);

      // R6 framing error then R9 break
      send_frame(8'hE4, 1'b0, 1'b0);
      check(frm_err && !rx_full && rx_data == 8'h77, "R6 framing error", {frm_err, rx_full, rx_data},
            {1'b1, 1'b0, 8'h77});
      @(negedge clk); rx_in = 1'b0;
      wait_clks(FRAME * TDIV / 2);
      check(!break_det, "R9 break not yet", break_det, 0);
      wait_clks(FRAME * TDIV / 2 + 40);
      check(break_det, "R9 break seen", break_det, 1);
      rx_in = 1'b1; wait_clks(8);
      check(!break_det, "R9 break released", break_det, 0);
      pulse(3);
      check(!frm_err && !rx_irq, "R6 R10 cleared", {frm_err, rx_irq}, 0);

      // R8 short low pulse ignored
      @(negedge clk); rx_in = 1'b0; wait_clks(5 * TDIV); rx_in = 1'b1;
      wait_clks(3 * BITC);
      check(!rx_full && !frm_err && rx_data == 8'h77, "R8 glitch ignored", {rx_full, frm_err}, 0);

      // R3 re-arm after address, mismatch path; R4 with marker
      pulse(0);
      send_frame(8'h12, 1'b0, 1'b1);
      check(!rx_full && filter_en, "R3 drop again", {rx_full, filter_en}, 2'b01);
      send_frame(8'hA5, 1'b1, 1'b1);
      check(rx_full && rx_data == 8'hA5 && !filter_en, "R4 second address", rx_data, 8'hA5);

      wait_clks(20);
      if (!done_run) begin
         done_run = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule